// File: doc/BRIEF.md
# Page-Mode Read Accelerator

This block sits between a host read port and a slow memory array. It serves reads at two speeds. The address space is cut into pages of four words. When the host addresses a page that is not held locally, the block fetches the whole page from the array in one request/response exchange and waits the long access latency. Any later address that stays in the same page, whether another word or, in byte mode, another byte, is served from the page buffer after the short page latency.

Dropping chip enable ends the current page, so the next read is always a full access. A write seen on the array side also invalidates the buffer. When the host holds its address steady long enough, the block goes into a sleep state. In that state the output word stays latched and valid and no array traffic occurs. A new address wakes the block with the normal timing.

Control states: `ST_IDLE` (chip enable low), `ST_FULL` (long access, page fetch pending or in flight), `ST_PAGE` (short in-page access), `ST_HOLD` (data valid, counting stable cycles) and `ST_SLEEP` (data valid and latched, array quiet). The transitions are:
- IDLE→FULL when chip enable rises.
- FULL→HOLD once the long latency has elapsed and the buffer is filled.
- FULL→FULL (restart) on an out-of-page address.
- PAGE→HOLD when the short latency has elapsed.
- HOLD→SLEEP after the stable interval.
- From HOLD, SLEEP or PAGE, an address change goes to PAGE on a buffer hit and to FULL on a miss.
- PAGE→FULL on an array write.
- Any state goes to IDLE when chip enable falls.

Top module: `pmr_accel`

## Requirements
- R1: After reset `h_valid`, `h_sleep` and `arr_req` are 0, and with chip enable low `h_doe` is 0.
- R2: When chip enable rises, `h_valid` rises `FULL_LAT` (default 9) clock edges after the edge that first samples the address. Exactly one `arr_req` pulse carries the page number `h_addr[AW-1:2]`, and `h_dout` shows the word selected by `h_addr[1:0]` from `arr_rdata` (word i in bits `[16i+15:16i]`).
- R3: From a valid state, an address in a different page takes `FULL_LAT` edges and a new array request.
- R4: From a valid state, an address in the same page takes `PAGE_LAT` (default 3) edges and issues no array request.
- R5: With `h_byte`=1 only `h_doe[7:0]` is set. `h_dout[7:0]` carries the upper half of the word when `h_bsel`=1 and the lower half when `h_bsel`=0, and `h_dout[15:8]` is 0. A change of `h_bsel` within a page is a page access.
- R6: A low pulse on `h_ce` clears `h_valid` on the next edge, and the following access takes `FULL_LAT` edges even for an unchanged address.
- R7: `SLEEP_LAT` (default 3) edges after `h_valid` rises with the address unchanged, `h_sleep` goes to 1. While asleep `h_valid` stays 1, `h_dout` holds, and no `arr_req` is issued.
- R8: An in-page address change during sleep clears `h_sleep` and is served with `PAGE_LAT` timing.
- R9: With `h_oe`=0 or `h_ce`=0, `h_doe` and `h_dout` are all zero.
- R10: An `arr_wr` pulse invalidates the page buffer, so the next in-page access takes `FULL_LAT` edges and returns freshly fetched data.
- R11: An out-of-page address that arrives while a fetch is in flight lets that fetch complete and discards its data. A new request for the new page follows, and `h_valid` rises `FULL_LAT` edges after the new address.
- R12: `arr_req` is a one-cycle pulse and is never raised while an earlier request still awaits `arr_ack`.
- R13: An address change while valid clears `h_valid` on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_ce | input | 1 | Host chip enable, active high |
| h_oe | input | 1 | Host output enable, active high |
| h_byte | input | 1 | 1 selects byte mode |
| h_bsel | input | 1 | Byte lane select inside a word (byte mode) |
| h_addr | input | AW | Host word address |
| h_dout | output | DW | Read data, zero where not driven |
| h_doe | output | DW | Per-bit output drive enable (0 = high impedance) |
| h_valid | output | 1 | Read data valid |
| h_sleep | output | 1 | Sleep state, data latched |
| arr_req | output | 1 | Page fetch request pulse |
| arr_page | output | AW-2 | Page number of the request |
| arr_ack | input | 1 | Page fetch response pulse |
| arr_rdata | input | 4*DW | Whole page returned with `arr_ack` |
| arr_wr | input | 1 | Array content changed; invalidate buffer |

## Verification
A full access makes `h_valid` rise in the cycle after edge `FULL_LAT` and a page access after edge `PAGE_LAT`, both counted from the edge that samples the new address. Sleep follows `SLEEP_LAT` edges after valid rises. The bench stamps each stimulus with the number of the next edge and queues the expected data for the cycle that many edges later. A monitor checks, at the falling edge, that `h_valid` is still low one cycle before that due cycle and that the data matches in it. The array model answers three cycles after it sees a request, so every fetch finishes before the long latency ends and the due cycle stays exact, also in the discarded-fetch case.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam int PW_BITS    = 2;
    localparam int PAGE_WORDS = 1 << PW_BITS;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FULL  = 3'd1,
        ST_PAGE  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_SLEEP = 3'd4
    } pmr_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pmr_outsel.sv
module pmr_outsel
    import pmr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic [AW+1:0]             key,
    input  logic [PAGE_WORDS*DW-1:0]  buf_data,
    input  logic                      ce,
    input  logic                      oe,
    output logic [DW-1:0]             sel_data,
    output logic [DW-1:0]             doe
);
    localparam int HW = DW / 2;

    logic [PW_BITS-1:0] wsel;
    logic [DW-1:0]      word;
    logic               byte_m;
    logic               bsel;

    assign wsel   = key[PW_BITS-1:0];
    assign byte_m = key[AW+1];
    assign bsel   = key[AW];
    assign word   = buf_data[wsel*DW +: DW];

    always_comb begin
        if (byte_m)
            sel_data = {{HW{1'b0}}, (bsel ? word[DW-1:HW] : word[HW-1:0])};
        else
            sel_data = word;
    end

    for (genvar g = 0; g < DW; g++) begin : g_lane
        if (g < HW) begin : g_low
            assign doe[g] = ce & oe;
        end else begin : g_high
            assign doe[g] = ce & oe & ~byte_m;
        end
    end

endmodule

// File: rtl/pmr_fetch.sv
module pmr_fetch
    import pmr_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      kill,
    input  logic                      arr_wr,
    input  logic [AW-PW_BITS-1:0]     fpage,
    input  logic                      arr_ack,
    input  logic [PAGE_WORDS*DW-1:0]  arr_rdata,
    output logic                      arr_req,
    output logic [AW-PW_BITS-1:0]     arr_page,
    output logic                      buf_valid,
    output logic [AW-PW_BITS-1:0]     buf_page,
    output logic [PAGE_WORDS*DW-1:0]  buf_data
);
    localparam int PGW = AW - PW_BITS;

    logic           pend_q;
    logic           infl_q;
    logic           stale_q;
    logic [PGW-1:0] want_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            infl_q    <= 1'b0;
            stale_q   <= 1'b0;
            want_q    <= '0;
            arr_req   <= 1'b0;
            arr_page  <= '0;
            buf_valid <= 1'b0;
            buf_page  <= '0;
            buf_data  <= '0;
        end else begin
            arr_req <= 1'b0;
            if (arr_ack) begin
                infl_q  <= 1'b0;
                stale_q <= 1'b0;
                if (!stale_q && !start && !kill && !arr_wr) begin
                    buf_data  <= arr_rdata;
                    buf_valid <= 1'b1;
                    buf_page  <= arr_page;
                end
            end
            if (pend_q && !infl_q && !start && !kill) begin
                arr_req  <= 1'b1;
                arr_page <= want_q;
                infl_q   <= 1'b1;
                pend_q   <= 1'b0;
            end
            if (arr_wr) begin
                buf_valid <= 1'b0;
                stale_q   <= infl_q & ~arr_ack;
            end
            if (start) begin
                pend_q    <= 1'b1;
                want_q    <= fpage;
                stale_q   <= infl_q & ~arr_ack;
                buf_valid <= 1'b0;
            end
            if (kill) begin
                pend_q    <= 1'b0;
                stale_q   <= infl_q & ~arr_ack;
                buf_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pmr_ctrl.sv
module pmr_ctrl
    import pmr_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int FULL_LAT  = 9,
    parameter int PAGE_LAT  = 3,
    parameter int SLEEP_LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic [AW+1:0]         key,
    input  logic                  arr_wr,
    input  logic                  buf_valid,
    input  logic [AW-PW_BITS-1:0] buf_page,
    input  logic [DW-1:0]         sel_data,
    output logic                  start,
    output logic                  kill,
    output logic                  valid,
    output logic                  sleep,
    output logic [DW-1:0]         dout_q
);
    localparam int PGW  = AW - PW_BITS;
    localparam int KW   = AW + 2;
    localparam int CMAX = max3(FULL_LAT, PAGE_LAT, SLEEP_LAT);
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] FULL_END  = CW'(FULL_LAT - 1);
    localparam logic [CW-1:0] PAGE_END  = CW'(PAGE_LAT - 1);
    localparam logic [CW-1:0] SLEEP_END = CW'(SLEEP_LAT - 1);

    pmr_state_e     st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic           restart;
    logic [KW-1:0]  key_q;
    logic [PGW-1:0] tgt_q;
    logic [PGW-1:0] page;
    logic           chg, hit, newpg;

    assign page  = key[AW-1:PW_BITS];
    assign chg   = (key != key_q);
    assign hit   = buf_valid && !arr_wr && (page == buf_page);
    assign newpg = (page != tgt_q);

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        start   = 1'b0;
        kill    = 1'b0;
        if (!ce) begin
            st_d    = ST_IDLE;
            kill    = 1'b1;
            restart = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d    = ST_FULL;
                    start   = 1'b1;
                    restart = 1'b1;
                end
                ST_FULL: begin
                    if (chg && newpg) begin
                        start   = 1'b1;
                        restart = 1'b1;
                    end else if (arr_wr) begin
                        start = 1'b1;
                    end else if (cnt_q >= FULL_END && buf_valid) begin
                        st_d    = ST_HOLD;
                        restart = 1'b1;
                    end
                end
                ST_PAGE, ST_HOLD, ST_SLEEP: begin
                    if (chg || (st_q == ST_PAGE && arr_wr)) begin
                        restart = 1'b1;
                        if (hit) begin
                            st_d = ST_PAGE;
                        end else begin
                            st_d  = ST_FULL;
                            start = 1'b1;
                        end
                    end else if (st_q == ST_PAGE && cnt_q >= PAGE_END) begin
                        st_d    = ST_HOLD;
                        restart = 1'b1;
                    end else if (st_q == ST_HOLD && cnt_q >= SLEEP_END) begin
                        st_d    = ST_SLEEP;
                        restart = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register and its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            key_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            key_q <= key;
            if (restart)
                cnt_q <= '0;
            else if (cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
            if (restart && ce)
                tgt_q <= page;
        end
    end

    // output register: data latched on entry to the valid state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (st_d == ST_HOLD && (st_q == ST_FULL || st_q == ST_PAGE)) begin
            dout_q <= sel_data;
        end
    end

    assign valid = (st_q == ST_HOLD) || (st_q == ST_SLEEP);
    assign sleep = (st_q == ST_SLEEP);

endmodule

// File: rtl/pmr_accel.sv
module pmr_accel
    import pmr_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int FULL_LAT  = 9,
    parameter int PAGE_LAT  = 3,
    parameter int SLEEP_LAT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      h_ce,
    input  logic                      h_oe,
    input  logic                      h_byte,
    input  logic                      h_bsel,
    input  logic [AW-1:0]             h_addr,
    output logic [DW-1:0]             h_dout,
    output logic [DW-1:0]             h_doe,
    output logic                      h_valid,
    output logic                      h_sleep,
    output logic                      arr_req,
    output logic [AW-PW_BITS-1:0]     arr_page,
    input  logic                      arr_ack,
    input  logic [PAGE_WORDS*DW-1:0]  arr_rdata,
    input  logic                      arr_wr
);
    localparam int PGW = AW - PW_BITS;

    logic [AW+1:0]            key;
    logic                     start, kill, buf_valid;
    logic [PGW-1:0]           buf_page;
    logic [PAGE_WORDS*DW-1:0] buf_data;
    logic [DW-1:0]            sel_data, dout_q;

    assign key = {h_byte, h_bsel, h_addr};

    pmr_ctrl #(
        .AW(AW), .DW(DW), .FULL_LAT(FULL_LAT),
        .PAGE_LAT(PAGE_LAT), .SLEEP_LAT(SLEEP_LAT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce(h_ce), .key(key), .arr_wr(arr_wr),
        .buf_valid(buf_valid), .buf_page(buf_page), .sel_data(sel_data),
        .start(start), .kill(kill), .valid(h_valid), .sleep(h_sleep),
        .dout_q(dout_q)
    );

    pmr_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .kill(kill),
        .arr_wr(arr_wr), .fpage(h_addr[AW-1:PW_BITS]),
        .arr_ack(arr_ack), .arr_rdata(arr_rdata),
        .arr_req(arr_req), .arr_page(arr_page),
        .buf_valid(buf_valid), .buf_page(buf_page), .buf_data(buf_data)
    );

    pmr_outsel #(.AW(AW), .DW(DW)) u_outsel (
        .key(key), .buf_data(buf_data), .ce(h_ce), .oe(h_oe),
        .sel_data(sel_data), .doe(h_doe)
    );

    assign h_dout = dout_q & h_doe;

endmodule

// File: rtl/pmr_accel_chk.sv
module pmr_accel_chk #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_ce,
    input logic          h_oe,
    input logic          h_byte,
    input logic [AW-1:0] h_addr,
    input logic [DW-1:0] h_dout,
    input logic [DW-1:0] h_doe,
    input logic          h_valid,
    input logic          h_sleep,
    input logic          arr_req,
    input logic          arr_ack
);
    logic outst;

    always_ff @(posedge clk) begin
        if (!rst_n)       outst <= 1'b0;
        else if (arr_req) outst <= 1'b1;
        else if (arr_ack) outst <= 1'b0;
    end

    p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |=> !arr_req);
    p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req |-> !outst);
    p_ce_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !h_ce |=> !h_valid);
    p_sleep_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_sleep |-> (h_valid && !arr_req));
    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sleep && $past(h_sleep) && $stable(h_doe)) |-> $stable(h_dout));
    p_byte_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        h_byte |-> (h_doe[DW-1:DW/2] == '0));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !h_oe |-> (h_dout == '0));
    p_addr_move_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ce && $past(h_ce) && !$stable(h_addr)) |=> !h_valid);

endmodule

bind pmr_accel pmr_accel_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_ce(h_ce), .h_oe(h_oe), .h_byte(h_byte),
    .h_addr(h_addr), .h_dout(h_dout), .h_doe(h_doe), .h_valid(h_valid),
    .h_sleep(h_sleep), .arr_req(arr_req), .arr_ack(arr_ack)
);

// File: tb/pmr_accel_test.sv
module pmr_accel_test;

    localparam int FULL = 9;
    localparam int PGL  = 3;
    localparam int SLP  = 3;
    localparam int DLY  = 3;

    typedef struct {
        int          due;
        logic [15:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_ce = 1'b0, h_oe = 1'b1, h_byte = 1'b0, h_bsel = 1'b0;
    logic [9:0]  h_addr = '0;
    logic [15:0] h_dout, h_doe;
    logic        h_valid, h_sleep, arr_req;
    logic [7:0]  arr_page;
    logic        arr_ack = 1'b0;
    logic [63:0] arr_rdata = '0;
    logic        arr_wr = 1'b0;

    int   cyc = 0, checks = 0, errors = 0, nreq = 0, salt = 0, ack_cnt = 0;
    int   lat_page = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pmr_accel uut (
        .clk(clk), .rst_n(rst_n), .h_ce(h_ce), .h_oe(h_oe), .h_byte(h_byte),
        .h_bsel(h_bsel), .h_addr(h_addr), .h_dout(h_dout), .h_doe(h_doe),
        .h_valid(h_valid), .h_sleep(h_sleep), .arr_req(arr_req),
        .arr_page(arr_page), .arr_ack(arr_ack), .arr_rdata(arr_rdata),
        .arr_wr(arr_wr)
    );

    function automatic logic [15:0] wexp(input int pg, input int w, input int s);
        return 16'((pg * 4 + w) * 37 + s * 4369 + 2565);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // array model: answers DLY cycles after it sees a request
    always @(negedge clk) begin
        if (ack_cnt > 0) begin
            ack_cnt = ack_cnt - 1;
            if (ack_cnt == 0) begin
                arr_ack = 1'b1;
                for (int i = 0; i < 4; i++)
                    arr_rdata[i*16 +: 16] = wexp(lat_page, i, salt);
            end
        end else begin
            arr_ack = 1'b0;
            if (arr_req) begin
                lat_page = int'(arr_page);
                ack_cnt  = DLY;
                nreq++;
            end
        end
    end

    // monitor: pops expected items at their due cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            if (cyc == sb[0].due - 1) begin
                chk(!h_valid, {sb[0].tag, " valid early"}, 32'(h_valid), 32'd0);
            end else if (cyc == sb[0].due) begin
                chk(h_valid && h_dout == sb[0].data, {sb[0].tag, " data"},
                    {15'd0, h_valid, h_dout}, {16'd1, sb[0].data});
                void'(sb.pop_front());
            end
        end
    end

    task automatic acc(input logic [9:0] a, input bit bm, input bit bs,
                       input int lat, input logic [15:0] d, input string tag);
        @(negedge clk);
        h_addr = a; h_byte = bm; h_bsel = bs; h_ce = 1'b1;
        sb.push_back('{cyc + 1 + lat, d, tag});
        wait (sb.size() == 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int n0;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        chk(!h_valid && !h_sleep && !arr_req && h_doe == 16'h0, "R1 reset",
            {h_valid, h_sleep, arr_req, h_doe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 first access
        acc(10'h014, 0, 0, FULL, wexp(5, 0, 0), "R2");
        chk(nreq == 1 && arr_page == 8'd5, "R2 request", 32'(nreq) << 8 | arr_page, 32'h105);
        chk(h_doe == 16'hFFFF, "R2 lanes", h_doe, 32'hFFFF);

        // R4 in-page
        acc(10'h016, 0, 0, PGL, wexp(5, 2, 0), "R4");
        chk(nreq == 1, "R4 no request", nreq, 1);

        // R7 sleep
        chk(!h_sleep, "R7 awake", h_sleep, 0);
        repeat (SLP - 1) @(negedge clk);
        chk(!h_sleep, "R7 before interval", h_sleep, 0);
        @(negedge clk);
        chk(h_sleep && h_valid, "R7 asleep", {h_sleep, h_valid}, 2'b11);
        held = h_dout;
        repeat (5) @(negedge clk);
        chk(h_dout == held && h_valid && nreq == 1, "R7 latched", h_dout, held);

        // R8 wake into page access
        acc(10'h015, 0, 0, PGL, wexp(5, 1, 0), "R8");
        chk(!h_sleep, "R8 woke", h_sleep, 0);

        // R3 new page
        acc(10'h040, 0, 0, FULL, wexp(16, 0, 0), "R3");
        chk(nreq == 2 && arr_page == 8'd16, "R3 request", arr_page, 16);

        // R5 byte mode
        acc(10'h041, 1, 1, PGL, {8'h00, wexp(16, 1, 0) >> 8}, "R5 upper");
        chk(h_doe == 16'h00FF, "R5 lanes", h_doe, 32'h00FF);
        acc(10'h041, 1, 0, PGL, {8'h00, wexp(16, 1, 0) & 16'h00FF}, "R5 lower");
        acc(10'h041, 0, 0, PGL, wexp(16, 1, 0), "R5 word again");
        chk(nreq == 2, "R5 no request", nreq, 2);

        // R9 output enable
        @(negedge clk); h_oe = 1'b0; #1;
        chk(h_doe == 16'h0 && h_dout == 16'h0, "R9 oe low", {h_doe, h_dout}, 0);
        h_oe = 1'b1; #1;
        chk(h_doe == 16'hFFFF, "R9 oe high", h_doe, 32'hFFFF);

        // R6 chip enable toggle
        @(negedge clk); h_ce = 1'b0;
        @(negedge clk);
        chk(!h_valid && h_doe == 16'h0, "R6 R9 ce low", {h_valid, h_doe}, 0);
        n0 = nreq;
        acc(10'h041, 0, 0, FULL, wexp(16, 1, 0), "R6");
        chk(nreq == n0 + 1, "R6 refetch", nreq, n0 + 1);

        // R10 array write invalidates
        @(negedge clk); arr_wr = 1'b1; salt = 1;
        @(negedge clk); arr_wr = 1'b0;
        chk(h_valid && h_dout == wexp(16, 1, 0), "R10 output kept", h_dout, wexp(16, 1, 0));
        acc(10'h042, 0, 0, FULL, wexp(16, 2, 1), "R10");

        // R11 out-of-page address during a fetch
        n0 = nreq;
        @(negedge clk); h_addr = 10'h080;
        @(negedge clk);
        @(negedge clk); h_addr = 10'h0C4;
        sb.push_back('{cyc + 1 + FULL, wexp(49, 0, 1), "R11"});
        wait (sb.size() == 0);
        chk(nreq == n0 + 2 && arr_page == 8'd49, "R11 requests",
            32'(nreq - n0) << 8 | arr_page, 32'h231);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule